// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps the wall-clock time and the calendar date as packed BCD bytes. A single-cycle enable pulse, normally once per second, advances seconds; the carries ripple through minutes, hours, day of month, month, a two-digit year and a century byte within the same clock edge. The day of month wraps at the real length of the current month, with leap years taken from the full four-digit year. A binary weekday counter advances whenever the day does.

A host sets the whole time in one cycle through a 64-bit parallel load port. It reads the fields back one byte at a time through a combinational read view. A failure flag comes up at power-up and holds the counters still. The first full load clears the flag and lets the clock run. Hour bit 7 is a stored mode flag (set means 24-hour display). The hour value in the low six bits always counts 00 to 23.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the bytes read 00 (seconds), 00 (minutes), 0x80 (hour: flag set, hour 00), 0x01 (day), 0x01 (month), 0x00 (year), 0x00 (weekday) and 0x20 (century), and the failure flag is 1.
- R2: While the failure flag is 1, tick pulses change no byte.
- R3: A load pulse writes every byte in one cycle, with byte i taken from load_bytes[8i+7:8i]. It clears the failure flag and takes priority over a tick in the same cycle. Hour bit 6 is stored as 0 and only weekday bits 2:0 are stored.
- R4: rd_addr 0..7 returns seconds, minutes, hour, day, month, year, weekday and century in that order. Address 8 returns the failure flag in bit 0 with the other bits 0. Addresses 9..15 return 0.
- R5: Each tick with the flag clear adds one second. Seconds and minutes count BCD 00..59, and each carries into the next field when it wraps to 00.
- R6: The hour's low six bits count BCD 00..23 and wrap to 00. Hour bit 7 is never changed by counting.
- R7: The day wraps from the last day of the month to 01 and advances the month. The last day is 30 for April, June, September and November, 31 for the other long months, 29 for February in leap years and 28 otherwise. Month 12 wraps to 01 and advances the year.
- R8: Year 99 wraps to 00 and adds one (BCD) to the century byte on the same tick. Year 00 is a leap year only when the century is a multiple of four (2000 yes, 1900 no).
- R9: The weekday (binary, 0..6) advances each time the hour wraps from 23, and goes from 6 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse that advances the time by one second |
| load | input | 1 | Parallel load strobe |
| load_bytes | input | 64 | Eight bytes to load, byte i at bits 8i+7:8i |
| rd_addr | input | 4 | Read byte address |
| rd_data | output | 8 | Byte selected by rd_addr |
| clk_fail | output | 1 | Failure flag, set at reset, cleared by load |

## Verification
A load or a tick acts on the clock edge where it is sampled, and the new byte values appear on rd_data right after that edge. The read path is purely combinational, so rd_data follows a change of rd_addr within the same cycle. The bench drives each strobe for exactly one cycle starting at a falling edge. It then reads all sixteen addresses in the low half of the period before the next rising edge. Every result is therefore compared in the first cycle it is due, against a binary model advanced in step with the strobes.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;
  localparam int NUM_BYTES   = 8;
  localparam int NUM_CNT     = 7;   // BCD counters (weekday is binary)
  localparam int BYTE_W      = 8;
  localparam int STATUS_ADDR = NUM_BYTES;

  // next packed-BCD value, two digits
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  // leap rule from two-digit year plus century byte
  function automatic logic leap_year(input logic [7:0] yr, input logic [7:0] cen);
    logic [6:0] yb, cb;
    yb = bcd_to_bin(yr);
    cb = bcd_to_bin(cen);
    if (yr == 8'h00) return (cb[1:0] == 2'd0);
    return (yb[1:0] == 2'd0);
  endfunction

  function automatic logic [7:0] month_last_day(input logic [7:0] mon,
                                                input logic [7:0] yr,
                                                input logic [7:0] cen);
    case (mon)
      8'h02:                      return leap_year(yr, cen) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_bcd_field.sv
`timescale 1ns/1ps
module rtc_bcd_field #(
  parameter logic [7:0] FLOOR   = 8'h00,
  parameter logic [7:0] RST_VAL = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] ld_val,
  input  logic       step,
  input  logic [7:0] ceil_val,
  output logic [7:0] q,
  output logic       at_ceil
);
  import rtc_cal_pkg::*;

  assign at_ceil = (q == ceil_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= RST_VAL;
    else if (load) q <= ld_val;
    else if (step) q <= at_ceil ? FLOOR : bcd_inc(q);
  end
endmodule

// File: rtl/rtc_read_view.sv
`timescale 1ns/1ps
module rtc_read_view #(
  parameter int N_BYTES = 8,
  parameter int ADDR_W  = 4
) (
  input  logic [N_BYTES-1:0][7:0] bytes,
  input  logic                    fail_bit,
  input  logic [ADDR_W-1:0]       addr,
  output logic [7:0]              data
);
  localparam int IDX_W = $clog2(N_BYTES);

  always_comb begin
    data = 8'h00;
    if (int'(addr) < N_BYTES)       data = bytes[addr[IDX_W-1:0]];
    else if (int'(addr) == N_BYTES) data = {7'd0, fail_bit};
  end
endmodule

// File: rtl/rtc_bcd_calendar.sv
`timescale 1ns/1ps
module rtc_bcd_calendar #(
  parameter logic [7:0] RST_CENTURY = 8'h20,
  parameter int         ADDR_W      = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  load,
  input  logic [63:0]           load_bytes,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [7:0]            rd_data,
  output logic                  clk_fail
);
  import rtc_cal_pkg::*;

  localparam int HOUR_IDX = 2;
  localparam int DAY_IDX  = 3;
  localparam int WD_BYTE  = 6;
  localparam int CEN_BYTE = 7;

  logic                     fail_q;
  logic                     mode_24h_q;
  logic [2:0]               wd_q;
  logic                     adv;
  logic [NUM_CNT-1:0][7:0]  fld_q;
  logic [NUM_CNT-1:0][7:0]  fld_ceil;
  logic [NUM_CNT-1:0]       fld_top;
  logic [NUM_CNT-1:0]       fld_step;
  logic [NUM_CNT-1:0]       fld_wrap;   // event: field wrapped this tick
  logic [NUM_BYTES-1:0][7:0] view;

  assign adv = tick && !fail_q && !load;

  always_comb begin
    fld_ceil[0] = 8'h59;
    fld_ceil[1] = 8'h59;
    fld_ceil[2] = 8'h23;
    fld_ceil[3] = month_last_day(fld_q[4], fld_q[5], fld_q[6]);
    fld_ceil[4] = 8'h12;
    fld_ceil[5] = 8'h99;
    fld_ceil[6] = 8'h99;
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_fld
    localparam int BI = (i == NUM_CNT - 1) ? CEN_BYTE : i;
    localparam logic [7:0] FLR = (i == DAY_IDX || i == DAY_IDX + 1) ? 8'h01 : 8'h00;
    localparam logic [7:0] RSV = (i == NUM_CNT - 1) ? RST_CENTURY : FLR;
    logic [7:0] ld_v;
    if (i == HOUR_IDX) begin : g_hr
      assign ld_v = {2'b00, load_bytes[8*BI +: 6]};
    end else begin : g_pl
      assign ld_v = load_bytes[8*BI +: 8];
    end
    if (i == 0) begin : g_first
      assign fld_step[i] = adv;
    end else begin : g_next
      assign fld_step[i] = adv && (&fld_top[i-1:0]);
    end
    assign fld_wrap[i] = fld_step[i] && fld_top[i];

    rtc_bcd_field #(.FLOOR(FLR), .RST_VAL(RSV)) u_fld (
      .clk(clk), .rst_n(rst_n), .load(load), .ld_val(ld_v),
      .step(fld_step[i]), .ceil_val(fld_ceil[i]),
      .q(fld_q[i]), .at_ceil(fld_top[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q     <= 1'b1;
      mode_24h_q <= 1'b1;
      wd_q       <= 3'd0;
    end else if (load) begin
      fail_q     <= 1'b0;
      mode_24h_q <= load_bytes[8*HOUR_IDX + 7];
      wd_q       <= load_bytes[8*WD_BYTE +: 3];
    end else if (fld_wrap[HOUR_IDX]) begin
      wd_q <= (wd_q >= 3'd6) ? 3'd0 : wd_q + 3'd1;
    end
  end

  always_comb begin
    for (int b = 0; b < NUM_BYTES; b++) view[b] = 8'h00;
    for (int f = 0; f < NUM_CNT - 1; f++) view[f] = fld_q[f];
    view[HOUR_IDX] = {mode_24h_q, 1'b0, fld_q[HOUR_IDX][5:0]};
    view[WD_BYTE]  = {5'd0, wd_q};
    view[CEN_BYTE] = fld_q[NUM_CNT-1];
  end

  rtc_read_view #(.N_BYTES(NUM_BYTES), .ADDR_W(ADDR_W)) u_view (
    .bytes(view), .fail_bit(fail_q), .addr(rd_addr), .data(rd_data)
  );

  assign clk_fail = fail_q;
endmodule

// File: rtl/rtc_cal_checker.sv
`timescale 1ns/1ps
module rtc_cal_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       load,
  input logic [7:0] ld_sec,
  input logic       fail,
  input logic       adv,
  input logic [7:0] sec,
  input logic [7:0] year,
  input logic [7:0] century,
  input logic [2:0] wd,
  input logic       year_wrap,
  input logic       day_step
);
  a_r2_frozen_when_failed: assert property (@(posedge clk) disable iff (!rst_n)
    fail && !load |=> $stable(sec) && $stable(century) && $stable(wd));

  a_r3_load_clears_fail: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !fail);

  a_r3_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> sec == $past(ld_sec));

  a_r5_sec_rollover: assert property (@(posedge clk) disable iff (!rst_n)
    adv && sec == 8'h59 |=> sec == 8'h00);

  a_r8_century_step: assert property (@(posedge clk) disable iff (!rst_n)
    year_wrap |=> year == 8'h00 && century != $past(century));

  a_r9_weekday_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    day_step && wd == 3'd6 |=> wd == 3'd0);
endmodule

bind rtc_bcd_calendar rtc_cal_checker u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .ld_sec(load_bytes[7:0]),
  .fail(fail_q), .adv(adv), .sec(fld_q[0]), .year(fld_q[5]),
  .century(fld_q[6]), .wd(wd_q), .year_wrap(fld_wrap[5]),
  .day_step(fld_wrap[2])
);

// File: tb/test_rtc_bcd_calendar.sv
`timescale 1ns/1ps
module test_rtc_bcd_calendar;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        load = 1'b0;
  logic [63:0] load_bytes = '0;
  logic [3:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        clk_fail;

  int n_checks = 0;
  int n_pass   = 0;
  // model state (binary)
  int ms, mm, mh, md, mmo, my, mc, mwd, mmode, mfail;

  always #2.5 clk = ~clk;

  rtc_bcd_calendar i_rtc_bcd_calendar (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
    .load_bytes(load_bytes), .rd_addr(rd_addr), .rd_data(rd_data),
    .clk_fail(clk_fail)
  );

  function automatic logic [7:0] b2b(input int v);
    return 8'((v / 10) * 16 + v % 10);
  endfunction

  function automatic int days_in(input int mo, input int yy, input int cc);
    int full;
    bit lp;
    full = cc * 100 + yy;
    lp = ((full % 4 == 0) && (full % 100 != 0)) || (full % 400 == 0);
    if (mo == 2) return lp ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] exp_byte(input int a);
    logic [7:0] hb;
    hb = b2b(mh);
    case (a)
      0: return b2b(ms);
      1: return b2b(mm);
      2: return {mmode[0], 1'b0, hb[5:0]};
      3: return b2b(md);
      4: return b2b(mmo);
      5: return b2b(my);
      6: return 8'(mwd);
      7: return b2b(mc);
      8: return 8'(mfail);
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_step();
    ms++;
    if (ms == 60) begin
      ms = 0; mm++;
      if (mm == 60) begin
        mm = 0; mh++;
        if (mh == 24) begin
          mh = 0; mwd = (mwd + 1) % 7; md++;
          if (md > days_in(mmo, my, mc)) begin
            md = 1; mmo++;
            if (mmo > 12) begin
              mmo = 1; my++;
              if (my == 100) begin my = 0; mc++; end
            end
          end
        end
      end
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_pass, n_checks);
    $finish;
  endtask

  // sample all addresses in the low phase after the edge
  task automatic check_all(input string req);
    for (int a = 0; a < 16; a++) begin
      rd_addr = 4'(a);
      #0.1;
      n_checks++;
      if (rd_data === exp_byte(a)) n_pass++;
      else $display("FAIL %s addr %0d: got %02h expected %02h", req, a, rd_data, exp_byte(a));
    end
    n_checks++;
    if (clk_fail === mfail[0]) n_pass++;
    else $display("FAIL %s clk_fail: got %0b expected %0b", req, clk_fail, mfail[0]);
  endtask

  // one-cycle strobe, called at a falling edge
  task automatic drive(input logic t, input logic l, input logic [63:0] d);
    tick = t; load = l; load_bytes = d;
    @(negedge clk);
    tick = 1'b0; load = 1'b0;
    if (l) mfail = 0;
    else if (t && mfail == 0) model_step();
  endtask

  task automatic load_state(input int s, input int m, input int h, input int d,
                            input int mo, input int y, input int c, input int w,
                            input int mode, input logic with_tick);
    logic [63:0] v;
    logic [7:0] hb;
    hb = b2b(h);
    v = {b2b(c), 8'(w), b2b(y), b2b(mo), b2b(d), {mode[0], 1'b0, hb[5:0]}, b2b(m), b2b(s)};
    ms = s; mm = m; mh = h; md = d; mmo = mo; my = y; mc = c; mwd = w; mmode = mode;
    drive(with_tick, 1'b1, v);
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    ms = 0; mm = 0; mh = 0; md = 1; mmo = 1; my = 0; mc = 20; mwd = 0; mmode = 1; mfail = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");       // reset values; R4 map incl. status byte

    for (int k = 0; k < 5; k++) begin
      drive(1'b1, 1'b0, '0);
      check_all("R2");     // ticks ignored while failed
    end

    // load with a tick in the same cycle; hour bit 6 and weekday bits 7:3 masked
    drive(1'b1, 1'b1, {8'h20, 8'hFB, 8'h24, 8'h06, 8'h15, 8'hC5, 8'h20, 8'h30});
    ms = 30; mm = 20; mh = 5; md = 15; mmo = 6; my = 24; mc = 20; mwd = 3; mmode = 1;
    check_all("R3");
    drive(1'b1, 1'b0, '0);
    check_all("R5");

    // seconds/minutes/hour carry over an hour and more
    load_state(0, 58, 22, 10, 3, 24, 20, 2, 1, 1'b0);
    check_all("R3");
    for (int k = 0; k < 3700; k++) begin
      drive(1'b1, 1'b0, '0);
      check_all("R5");
    end

    // hour wrap with mode bit clear: bit 7 stays 0
    load_state(50, 59, 23, 4, 7, 10, 20, 1, 0, 1'b0);
    for (int k = 0; k < 20; k++) begin
      drive(1'b1, 1'b0, '0);
      check_all("R6");
    end

    // month ends over several years and centuries
    for (int yi = 0; yi < 7; yi++) begin
      int yy, cc;
      case (yi)
        0: begin yy = 0;  cc = 20; end
        1: begin yy = 0;  cc = 19; end
        2: begin yy = 1;  cc = 20; end
        3: begin yy = 4;  cc = 20; end
        4: begin yy = 96; cc = 19; end
        5: begin yy = 99; cc = 20; end
        default: begin yy = 99; cc = 19; end
      endcase
      for (int mo = 1; mo <= 12; mo++) begin
        int last;
        last = days_in(mo, yy, cc);
        load_state(59, 59, 23, last - 1, mo, yy, cc, mo % 7, 1, 1'b0);
        drive(1'b1, 1'b0, '0);
        check_all("R7");
        for (int rep = 0; rep < 86400; rep += 86400) begin
          load_state(59, 59, 23, last, mo, yy, cc, mo % 7, 1, 1'b0);
        end
        drive(1'b1, 1'b0, '0);
        if (yy == 99 && mo == 12) check_all("R8");
        else check_all("R7");
      end
    end

    // weekday wrap 6 -> 0
    load_state(59, 59, 23, 12, 5, 33, 20, 6, 1, 1'b0);
    drive(1'b1, 1'b0, '0);
    check_all("R9");
    drive(1'b1, 1'b0, '0);
    check_all("R9");

    // status address after a load reads 0; unused addresses read 0
    check_all("R4");
    summary();
  end
endmodule